// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Timer Compare Override

This block controls a group of general-purpose pins through three software-visible registers: an output latch, a direction mask and a drive-strength mask. It drives pad wrappers with a per-pin output value, an output enable and a reduced-drive select. A fourth address returns the synchronized pin levels. Software reaches all four through a simple single-cycle bus. Reads are combinational and writes take effect at the next clock edge.

A timer may take over any pin through a per-pin compare-enable and compare-value pair. While a pin's compare enable is high, the pin is forced to drive and carries the timer's compare value. The stored direction bit is left as it was, and it resumes control of the pin once the enable falls. Every pin level passes through a two-flop synchronizer on the bus clock. The synchronized levels feed both the read path and the capture outputs toward the timer, whatever the pin direction. A change of direction or pin level therefore shows up on reads after up to two clock cycles.

Top module: `gpio_port_ovr`

## Requirements
- R1: While `rst_n` is low, the output latch, direction mask and drive mask all hold zero, so every pin is an input with `pad_oe`, `pad_out` and `pad_weak` at zero.
- R2: With no compare override, `pad_oe[i]` equals the direction bit i, where 1 means drive and 0 means high impedance.
- R3: While `tmr_oc_en[i]` is high, `pad_oe[i]` is 1 and the direction mask read back at address 1 keeps its stored value.
- R4: When `tmr_oc_en[i]` falls, `pad_oe[i]` again follows direction bit i in the same cycle.
- R5: `pad_out[i]` equals `tmr_oc_val[i]` while `tmr_oc_en[i]` is high, and output-latch bit i otherwise.
- R6: `cap_level` equals `pin_in` as sampled two rising clock edges earlier, regardless of direction or override.
- R7: A read of address 0 returns, per bit, the output-latch bit when the pin is driving (direction or override) and the synchronized pin level when it is not.
- R8: A read of address 3 returns the synchronized pin levels for every bit, and a write to address 3 changes no register.
- R9: `pad_weak` equals the drive mask (1 selects reduced drive), and the drive mask changes no other output.
- R10: Addresses 0, 1 and 2 (latch, direction, drive) accept writes at any time when `bus_sel` and `bus_wr` are both high, take the value at the next rising edge and read it back. A cycle without both strobes writes nothing. `bus_rdata` is zero while `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | 0 latch, 1 direction, 2 drive, 3 pin levels |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pin levels from the pads |
| tmr_oc_en | input | 8 | Per-pin timer compare enable (override) |
| tmr_oc_val | input | 8 | Per-pin timer compare output value |
| pad_out | output | 8 | Value driven toward each pad |
| pad_oe | output | 8 | Output enable toward each pad |
| pad_weak | output | 8 | Reduced-drive select toward each pad |
| cap_level | output | 8 | Synchronized pin levels for timer capture |

## Verification
The bench turns the compare override on and off on pins whose direction bits differ. A design that wrote the override into the direction mask would read back a changed mask, and one that latched the override would keep pins driving after release. It changes pin levels and direction in the same cycles as latch reads. A design with the wrong synchronizer depth, or one that read raw pins, would return levels a cycle early or late. Writes to the pin-level address and writes without both strobes catch decoders that corrupt the latch or masks.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_LATCH = 2'd0,
    ADDR_DIR   = 2'd1,
    ADDR_DRIVE = 2'd2,
    ADDR_PINS  = 2'd3
  } port_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign sync_out = stg_q[LAST];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  port_addr_e       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] weak_q
);
  logic [WIDTH-1:0] latch_d, dir_d, weak_d;
  logic             latch_ce, dir_ce, weak_ce;

  always_comb begin
    latch_ce = wr_en && (addr == ADDR_LATCH);
    dir_ce   = wr_en && (addr == ADDR_DIR);
    weak_ce  = wr_en && (addr == ADDR_DRIVE);
    latch_d  = latch_ce ? wdata : latch_q;
    dir_d    = dir_ce   ? wdata : dir_q;
    weak_d   = weak_ce  ? wdata : weak_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      weak_q  <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      weak_q  <= weak_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (latch_q == '0 && dir_q == '0 && weak_q == '0));

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_DIR) |=> $stable(dir_q));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_LATCH) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] sync_lvl,
  input  logic [WIDTH-1:0] oc_en,
  input  logic [WIDTH-1:0] oc_val,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] latch_rd
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic drive;
    always_comb begin
      drive       = oc_en[i] | dir_q[i];
      pad_oe[i]   = drive;
      pad_out[i]  = oc_en[i] ? oc_val[i] : latch_q[i];
      latch_rd[i] = drive ? latch_q[i] : sync_lvl[i];
    end
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] tmr_oc_en,
  input  logic [WIDTH-1:0] tmr_oc_val,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_weak,
  output logic [WIDTH-1:0] cap_level
);
  port_addr_e       addr;
  logic             wr_en;
  logic [WIDTH-1:0] latch_q, dir_q, weak_q, sync_lvl, latch_rd;

  assign addr  = port_addr_e'(bus_addr);
  assign wr_en = bus_sel & bus_wr;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .weak_q(weak_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_lvl)
  );

  gpio_pinmux #(.WIDTH(WIDTH)) u_mux (
    .latch_q(latch_q), .dir_q(dir_q), .sync_lvl(sync_lvl),
    .oc_en(tmr_oc_en), .oc_val(tmr_oc_val),
    .pad_out(pad_out), .pad_oe(pad_oe), .latch_rd(latch_rd)
  );

  assign pad_weak  = weak_q;
  assign cap_level = sync_lvl;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (addr)
        ADDR_LATCH: bus_rdata = latch_rd;
        ADDR_DIR:   bus_rdata = dir_q;
        ADDR_DRIVE: bus_rdata = weak_q;
        ADDR_PINS:  bus_rdata = sync_lvl;
        default:    bus_rdata = '0;
      endcase
    end
  end

  // Cycles since reset, for the capture-latency check only.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R3
  oc_forces_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_oc_en & ~pad_oe) == '0);

  // R5
  oc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ tmr_oc_val) & tmr_oc_en) == '0);

  // R6
  cap_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (cap_level == $past(pin_in, 2)));

  // R9
  weak_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 2'd2 |=> pad_weak == $past(bus_wdata));
endmodule

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, tmr_oc_en, tmr_oc_val;
  logic [7:0] pad_out, pad_oe, pad_weak, cap_level;

  int errors = 0;
  int checks = 0;

  gpio_port_ovr i_gpio_port_ovr (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_weak(pad_weak),
    .cap_level(cap_level)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model
  logic [7:0] m_latch, m_dir, m_weak;
  logic [7:0] m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 8'h00; m_dir = 8'h00; m_weak = 8'h00;
      m_hist  = {8'h00, 8'h00};
    end else begin
      if (bus_sel && bus_wr) begin
        if (bus_addr == 2'd0) m_latch = bus_wdata;
        if (bus_addr == 2'd1) m_dir   = bus_wdata;
        if (bus_addr == 2'd2) m_weak  = bus_wdata;
      end
      m_hist.push_back(pin_in);
      void'(m_hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] syn, drv, e_out, e_rd;
    syn   = m_hist[0];
    drv   = tmr_oc_en | m_dir;
    e_out = (tmr_oc_en & tmr_oc_val) | (~tmr_oc_en & m_latch);
    e_rd  = 8'h00;
    if (bus_sel) begin
      case (bus_addr)
        2'd0: e_rd = (drv & m_latch) | (~drv & syn);
        2'd1: e_rd = m_dir;
        2'd2: e_rd = m_weak;
        default: e_rd = syn;
      endcase
    end
    chk("R1 R2 R3 R4 pad_oe", pad_oe, drv);
    chk("R1 R5 pad_out", pad_out, e_out);
    chk("R1 R9 pad_weak", pad_weak, m_weak);
    chk("R6 cap_level", cap_level, syn);
    chk("R3 R7 R8 R10 bus_rdata", bus_rdata, e_rd);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic bus(input logic s, input logic w, input logic [1:0] a, input logic [7:0] d);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    step();
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
    bus_wdata = 8'h00; pin_in = 8'h5A; tmr_oc_en = 8'h00; tmr_oc_val = 8'hFF;
    // R1: reset state, reads of direction and drive
    bus(1'b1, 1'b0, 2'd1, 8'h00);
    bus(1'b1, 1'b1, 2'd2, 8'hFF);
    rst_n = 1'b1;
    // R10 R2 R9: writes and readback
    bus(1'b1, 1'b1, 2'd1, 8'hF0);
    bus(1'b1, 1'b0, 2'd1, 8'h00);
    bus(1'b1, 1'b1, 2'd0, 8'hA5);
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    bus(1'b1, 1'b1, 2'd2, 8'h3C);
    bus(1'b1, 1'b0, 2'd2, 8'h00);
    // R7 R6: pin change seen after two edges on latch read
    pin_in = 8'hC3;
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    bus(1'b1, 1'b0, 2'd3, 8'h00);
    // R8 R10: ignored writes
    bus(1'b1, 1'b1, 2'd3, 8'hFF);
    bus(1'b0, 1'b1, 2'd1, 8'h0F);
    bus(1'b1, 1'b0, 2'd1, 8'h00);
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    // R3 R5: override forces drive, direction mask untouched
    tmr_oc_en = 8'h0F; tmr_oc_val = 8'h05;
    bus(1'b1, 1'b0, 2'd1, 8'h00);
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    // R4: release returns control to the direction mask
    tmr_oc_en = 8'h00;
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    bus(1'b1, 1'b0, 2'd1, 8'h00);
    // Mixed random traffic, all requirements
    for (int n = 0; n < 400; n++) begin
      pin_in     = 8'($urandom);
      tmr_oc_en  = 8'($urandom) & 8'($urandom);
      tmr_oc_val = 8'($urandom);
      bus(1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
    end
    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    tmr_oc_en = 8'h00;
    bus(1'b1, 1'b0, 2'd2, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule